// File: doc/BRIEF.md
# Software-Raisable Interrupt Status Unit

This block gathers interrupt causes into one 32-bit status word. A cause bit is set when software writes to the raise register, or when a sibling engine pulses the matching bit of the event input. The bit stays set until software writes a one to that position in the acknowledge register. While any cause is pending, a level interrupt line is held high. In message mode the block also produces a one-cycle pulse for each raise that sets a bit that was clear before. The level line keeps following the status word in message mode, so the interrupt handler still has to acknowledge the cause.

Software uses a simple register port. There is a write path with an enable, a byte address and data. There is also an independent combinational read path. The pulse logic is a two-state machine. `MSG_IDLE` moves to `MSG_FIRE` when a new bit is set while message mode is selected. `MSG_FIRE` stays in `MSG_FIRE` on a further new bit, and otherwise returns to `MSG_IDLE`. `MSG_IDLE` stays in `MSG_IDLE` in every other case. The pulse output is high exactly while the machine is in `MSG_FIRE`.

Top module: `isu_top`

## Requirements
- R1: After reset the status word is zero, and both `irq_level` and `irq_pulse` are low.
- R2: Reading byte offset 0x24 returns the current status word in the same cycle.
- R3: A write to byte offset 0x60 ORs the written data into the status word, taking effect at the next clock edge.
- R4: A write to byte offset 0x64 clears every status bit whose written data bit is 1. Bits written as 0 keep their value.
- R5: Each bit of `evt_raise` that is high at a clock edge sets the same status bit.
- R6: When an `evt_raise` bit and an acknowledge write to the same bit arrive in the same cycle, that bit ends up set.
- R7: `irq_level` is high exactly when the status word is nonzero, in both level mode and message mode.
- R8: With `msg_mode`=1, a raise that sets at least one previously clear bit makes `irq_pulse` high for one cycle. The pulse appears in the cycle in which the new status is visible.
- R9: No pulse is produced when a raise only sets bits that are already set, and no pulse is produced when `msg_mode`=0.
- R10: Reads of byte offsets 0x60 and 0x64 return zero.
- R11: With no write and no event, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_mode | input | 1 | 1 selects message-pulse signalling in addition to the level line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the combinational read |
| rd_data | output | 32 | Read data |
| evt_raise | input | 32 | Per-bit event pulses from sibling engines |
| irq_level | output | 1 | Level interrupt, high while any cause is pending |
| irq_pulse | output | 1 | One-cycle message pulse on a new cause |

## Verification
The hardest case to reach is an engine event arriving in the same cycle as a software acknowledge of that same bit. From the ports it looks like nothing happened to that bit. The stimulus drives `evt_raise` and an acknowledge write in one cycle, then reads the status word back to confirm that the bit is still set and that no pulse fired. It also repeats raises of bits that are already set in message mode, to separate "new bit" from "any raise".

// File: rtl/isu_pkg.sv
package isu_pkg;

    typedef enum logic {
        MSG_IDLE = 1'b0,
        MSG_FIRE = 1'b1
    } msg_state_e;

endpackage

// File: rtl/isu_bus_decode.sv
module isu_bus_decode #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int STATUS_OFF = 'h24,
    parameter int RAISE_OFF  = 'h60,
    parameter int ACK_OFF    = 'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] sw_set_o,
    output logic [DATA_W-1:0] sw_clr_o,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STATUS_OFF);
    localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(RAISE_OFF);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(ACK_OFF);

    always_comb begin
        sw_set_o = '0;
        sw_clr_o = '0;
        if (wr_en && wr_addr == A_RAISE) sw_set_o = wr_data;
        if (wr_en && wr_addr == A_ACK)   sw_clr_o = wr_data;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_STAT) rd_data = status_i;
    end

    // R10: write-only offsets read as zero
    p_wo_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_RAISE || rd_addr == A_ACK) |-> rd_data == '0);

endmodule

// File: rtl/isu_status_reg.sv
module isu_status_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_i,
    input  logic [DATA_W-1:0] clr_i,
    output logic [DATA_W-1:0] status_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_i) | set_i;
    end

    // R3/R5/R6: every requested set bit is present afterwards, even under a clear
    p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R4: acknowledged bits that are not raised again end up clear
    p_clr_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((status_o & $past(clr_i) & ~$past(set_i)) == '0));

    // R11: quiet cycles keep the word
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(status_o));

endmodule

// File: rtl/isu_msg_fsm.sv
module isu_msg_fsm #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_mode,
    input  logic [DATA_W-1:0] set_i,
    input  logic [DATA_W-1:0] status_i,
    output logic              pulse_o
);
    import isu_pkg::*;

    msg_state_e state_q, state_d;
    logic       fresh;

    assign fresh = msg_mode && ((set_i & ~status_i) != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MSG_IDLE: state_d = fresh ? MSG_FIRE : MSG_IDLE;
            MSG_FIRE: state_d = fresh ? MSG_FIRE : MSG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MSG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse_o = (state_q == MSG_FIRE);
    end

    // R9: level mode never pulses
    p_no_pulse_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_mode |=> !pulse_o);

    // R8: a pulse means some bit was clear one cycle ago
    p_pulse_new_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> ($past(status_i) != status_i));

endmodule

// File: rtl/isu_top.sv
module isu_top #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int STATUS_OFF = 'h24,
    parameter int RAISE_OFF  = 'h60,
    parameter int ACK_OFF    = 'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] evt_raise,
    output logic              irq_level,
    output logic              irq_pulse
);
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] sw_set;
    logic [DATA_W-1:0] sw_clr;
    logic [DATA_W-1:0] all_set;

    assign all_set = sw_set | evt_raise;

    isu_bus_decode #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_OFF(STATUS_OFF),
        .RAISE_OFF(RAISE_OFF), .ACK_OFF(ACK_OFF)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .status_i(status),
        .sw_set_o(sw_set), .sw_clr_o(sw_clr), .rd_data(rd_data)
    );

    isu_status_reg #(.DATA_W(DATA_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_i(all_set), .clr_i(sw_clr),
        .status_o(status)
    );

    isu_msg_fsm #(.DATA_W(DATA_W)) u_msg (
        .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .set_i(all_set),
        .status_i(status), .pulse_o(irq_pulse)
    );

    assign irq_level = (status != '0);

    // R7: a pulse is never seen without the level line
    p_pulse_implies_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_level);

    // R7: any raise leaves the level line high afterwards
    p_raise_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (all_set != '0) |=> irq_level);

endmodule

// File: tb/isu_top_tb.sv
`timescale 1ns/1ps
module isu_top_tb;
    localparam logic [7:0] A_STAT  = 8'h24;
    localparam logic [7:0] A_RAISE = 8'h60;
    localparam logic [7:0] A_ACK   = 8'h64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = A_STAT;
    logic [31:0] rd_data;
    logic [31:0] evt_raise = '0;
    logic        irq_level;
    logic        irq_pulse;

    typedef struct {
        string       tag;
        logic [31:0] rd;
        logic        lvl;
        logic        pls;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] mstat = '0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    isu_top u_dut (
        .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .evt_raise(evt_raise), .irq_level(irq_level),
        .irq_pulse(irq_pulse)
    );

    task automatic compare(string tag, logic [31:0] rd, logic lvl, logic pls,
                           logic [31:0] erd, logic elvl, logic epls);
        n_chk++;
        if (rd !== erd || lvl !== elvl || pls !== epls) begin
            n_fail++;
            $display("FAIL %s: rd=%h lvl=%b pls=%b expected rd=%h lvl=%b pls=%b",
                     tag, rd, lvl, pls, erd, elvl, epls);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(string tag, logic mode, logic we, logic [7:0] wa,
                        logic [31:0] wd, logic [31:0] ev, logic [7:0] ra);
        logic [31:0] setv, clrv, nxt;
        exp_t it;
        @(negedge clk);
        msg_mode = mode; wr_en = we; wr_addr = wa; wr_data = wd;
        evt_raise = ev; rd_addr = ra;
        setv = ev | ((we && wa == A_RAISE) ? wd : 32'h0);
        clrv = (we && wa == A_ACK) ? wd : 32'h0;
        nxt  = (mstat & ~clrv) | setv;
        it.tag = tag;
        it.rd  = (ra == A_STAT) ? nxt : 32'h0;
        it.lvl = (nxt != 0);
        it.pls = mode && ((setv & ~mstat) != 0);
        mstat  = nxt;
        sb.push_back(it);
        @(posedge clk);
    endtask

    // monitor: pops one expected item per edge after the stimulus lands
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compare(e.tag, rd_data, irq_level, irq_pulse, e.rd, e.lvl, e.pls);
            end
        end
    end

    task automatic idle(string tag, logic mode, logic [7:0] ra);
        step(tag, mode, 1'b0, 8'h0, 32'h0, 32'h0, ra);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: rd=%h lvl=%b pls=%b expected completion",
                     rd_data, irq_level, irq_pulse);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset", rd_data, irq_level, irq_pulse, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        step("R3 R9 raise level mode", 0, 1, A_RAISE, 32'h5, 0, A_STAT);
        idle("R11 hold", 0, A_STAT);
        idle("R10 read raise offset", 0, A_RAISE);
        idle("R10 read ack offset", 0, A_ACK);
        step("R4 partial ack", 0, 1, A_ACK, 32'h1, 0, A_STAT);
        step("R7 ack last bit level low", 0, 1, A_ACK, 32'h4, 0, A_STAT);
        step("R8 new bit msg mode", 1, 1, A_RAISE, 32'h10, 0, A_STAT);
        idle("R8 pulse one cycle", 1, A_STAT);
        step("R9 R7 re-raise set bit", 1, 1, A_RAISE, 32'h10, 0, A_STAT);
        step("R5 R8 event new bit", 1, 0, 8'h0, 32'h0, 32'h100, A_STAT);
        step("R6 event vs ack", 1, 1, A_ACK, 32'h110, 32'h100, A_STAT);
        step("R4 ack zero bits kept", 1, 1, A_ACK, 32'h0, 0, A_STAT);
        step("R2 R7 clear all msg mode", 1, 1, A_ACK, 32'hFFFF_FFFF, 0, A_STAT);
        step("R8 back-to-back new 1", 1, 1, A_RAISE, 32'h1, 0, A_STAT);
        step("R8 back-to-back new 2", 1, 0, 8'h0, 32'h0, 32'h2, A_STAT);
        idle("R11 hold msg", 1, A_STAT);
        for (int i = 0; i < 8; i++) begin
            step("R3 R8 sweep raise", i[0], 1, A_RAISE, 32'h1 << (i * 4), 32'h0, A_STAT);
            step("R5 sweep event", 1, 0, 8'h0, 32'h0, 32'h80 << i, A_STAT);
            step("R4 sweep ack", 0, 1, A_ACK, 32'h3 << (i * 3), 32'h0, A_STAT);
        end
        step("R6 event on acked bit", 0, 1, A_ACK, 32'hFFFF_FFFF, 32'h8000_0000, A_STAT);
        step("R4 final clear", 0, 1, A_ACK, 32'hFFFF_FFFF, 0, A_STAT);
        idle("R10 raise readback after clear", 0, A_RAISE);
        idle("R7 idle end", 0, A_STAT);
        @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule